// File: doc/BRIEF.md
# CD Decoder Controller Host Register File

This block is the byte-wide register interface between a host processor and a CD data-decoder controller. The host sets a 4-bit register pointer through a dedicated load port. It then issues read or write strobes. Each strobe acts on the register that the pointer selects, and the pointer then normally steps to the next index on its own. The read map and the write map are separate: the same index names one register when read and a different one when written.

The block holds the following state:

- the transfer byte count and the data address, both handed to the transfer engine;
- the write address and the block pointer;
- four header bytes and four decode-status bytes;
- three decoder control bytes, a host configuration byte, a host status byte and a subcode output byte.

The block also produces three one-cycle strobes: transfer-start, acknowledge and soft-reset. It records which registers the host has read since the last reset. That history decides whether reading the last decode-status byte re-arms that byte.

A small state machine tracks whether a data transfer is running. It has two states:

- `XF_IDLE`: no transfer. The transition START (a trigger write while transfers are enabled) moves it to `XF_BUSY`.
- `XF_BUSY`: a transfer runs. The transition STOP returns it to `XF_IDLE`. STOP is any of: a configuration write that disables transfers, a soft reset, or the `xfer_done` event from the engine.
- START has priority over STOP when both occur in the same cycle.

Top module: `cdc_regfile`

## Requirements
- R1: After reset, all registers take their reset values and the pointer is 0. The reset values are: host status 0xFF; header bytes 0..3 = 00,00,00,01; write address 4704; decode-status byte 0 = 0x80; every other register 0.
- R2: `rdata` shows the register the pointer selects, combinationally. The read indices are:
  - 0: `cmd_in`
  - 1: host status
  - 2, 3: byte count low, high
  - 4..7: header bytes 0..3
  - 8, 9: block pointer low, high
  - 10, 11: write address low, high
  - 12..15: decode-status bytes 0..3
- R3: A read strobe (without a write strobe) at pointer n < 15 moves the pointer to n+1 on the next edge. A read at 15 leaves the pointer unchanged.
- R4: A write strobe stores `wdata` into the register at the pointer, and the pointer then steps by one. Writes at indices 6, 7, 14 and 15 do not step the pointer. The write indices are:
  - 0: subcode out
  - 1: host config
  - 2, 3: byte count low, high
  - 4, 5: data address low, high
  - 6: trigger
  - 7: acknowledge
  - 8, 9: write address low, high
  - 10, 11: control 0, 1
  - 12, 13: block pointer low, high
  - 14: control 2
  - 15: soft reset
- R5: `ptr_ld` loads `ptr_ld_val` on the next edge and takes priority over any stepping. A strobe in the same cycle still acts on the old pointer.
- R6: A host-config write with bit 1 clear zeroes the byte count, sets host status bit 3 and ends any transfer.
- R7: A trigger write while host-config bit 1 is set clears host status bit 3, enters `XF_BUSY`, and raises `xfer_trig` for one cycle. With bit 1 clear, a trigger write changes nothing.
- R8: An acknowledge write sets host status bit 6 and raises `xfer_ack` for one cycle.
- R9: Reading decode-status byte 3 sets host status bit 5. If, in addition, control 0 bit 7 and host-config bit 5 are set, and reads of indices 1, 4-9, 12, 13 and 14 have all occurred since reset, decode-status byte 3 becomes 0x80.
- R10: `hdr_upd` loads the header. If control 1 bit 0 is set, all four header bytes become 0. Otherwise they become `msf_min`, `msf_sec`, `msf_frm` and 0x01, in byte order 0..3.
- R11: A write at index 15 restores every register to its R1 value and clears the read history. It leaves the pointer unchanged and raises `soft_rst` for one cycle.
- R12: When read and write strobes occur together, only the write takes effect.
- R13: `dec_evt` clears host status bit 5. `xfer_done` ends the transfer, sets host status bit 3, and clears bit 6 when host-config bit 6 is set. A host access in the same cycle overrides these events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Load register pointer |
| ptr_ld_val | input | 4 | Pointer load value |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| ptr_q | output | 4 | Current register pointer |
| cmd_in | input | 8 | Command-in byte from the decoder |
| hdr_upd | input | 1 | Header update pulse |
| msf_min | input | 8 | BCD minute |
| msf_sec | input | 8 | BCD second |
| msf_frm | input | 8 | BCD frame |
| dec_evt | input | 1 | Decode interrupt event |
| xfer_done | input | 1 | Transfer-end event from the engine |
| xfer_active | output | 1 | Transfer running (state `XF_BUSY`) |
| xfer_trig | output | 1 | Transfer start strobe |
| xfer_ack | output | 1 | Acknowledge strobe |
| soft_rst | output | 1 | Soft reset strobe |
| bcnt_q | output | 16 | Byte count |
| daddr_q | output | 16 | Data address |
| ctl_q | output | 24 | Control bytes {2,1,0} |
| subout_q | output | 8 | Subcode out byte |
| hcfg_q | output | 8 | Host config byte |

## Verification
The register map is tested with sequential read and write sweeps that start at different pointer loads, including loads issued together with a strobe. These sweeps distinguish a wrong map entry from a wrong pointer step, and they catch missing holds at indices 6, 7, 14 and 15. The trigger is written with transfers enabled and with transfers disabled, which separates a gated start from an ungated one. The status-byte-3 rule is tested three ways: with an empty read history, with history missing only index 14, and with complete history. This shows that the mask is honoured exactly. Collisions between engine events and host writes, and between read and write strobes, check the priority order.

// File: rtl/cdc_reg_pkg.sv
package cdc_reg_pkg;
    localparam int PTR_W  = 4;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 16;

    typedef enum logic [0:0] {XF_IDLE, XF_BUSY} xf_state_e;

    // write indices with side effects or pointer holds
    localparam logic [PTR_W-1:0] WR_SUBOUT = 4'd0;
    localparam logic [PTR_W-1:0] WR_HCFG   = 4'd1;
    localparam logic [PTR_W-1:0] WR_TRIG   = 4'd6;
    localparam logic [PTR_W-1:0] WR_ACK    = 4'd7;
    localparam logic [PTR_W-1:0] WR_CTL2   = 4'd14;
    localparam logic [PTR_W-1:0] WR_SRST   = 4'd15;
    localparam logic [PTR_W-1:0] RD_DSTS3  = 4'd15;

    // bit positions
    localparam int HCFG_XFER_EN = 1;
    localparam int HCFG_DEC_IE  = 5;
    localparam int HCFG_DTE_IE  = 6;
    localparam int HSTS_IDLE    = 3;
    localparam int HSTS_DEC_N   = 5;
    localparam int HSTS_DTE_N   = 6;
    localparam int DCTL0_ARM    = 7;
    localparam int DCTL1_ZHDR   = 0;

    typedef struct packed {
        logic [BYTE_W-1:0]        subout;
        logic [BYTE_W-1:0]        hcfg;
        logic [BYTE_W-1:0]        hsts;
        logic [CNT_W-1:0]         bcnt;
        logic [CNT_W-1:0]         daddr;
        logic [CNT_W-1:0]         waddr;
        logic [CNT_W-1:0]         bptr;
        logic [3:0][BYTE_W-1:0]   hdr;
        logic [3:0][BYTE_W-1:0]   dsts;
        logic [2:0][BYTE_W-1:0]   dctl;
    } regs_t;

    localparam regs_t REG_RST = '{
        subout: '0,
        hcfg:   '0,
        hsts:   8'hFF,
        bcnt:   '0,
        daddr:  '0,
        waddr:  16'd4704,
        bptr:   '0,
        hdr:    32'h0100_0000,
        dsts:   32'h0000_0080,
        dctl:   '0
    };
endpackage

// File: rtl/cdc_ptr_seq.sv
module cdc_ptr_seq
    import cdc_reg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             rd_stb,
    input  logic             wr_stb,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = {PTR_W{1'b1}};

    logic wr_hold;
    logic step;

    always_comb begin
        wr_hold = (ptr_o == WR_TRIG) || (ptr_o == WR_ACK) ||
                  (ptr_o == WR_CTL2) || (ptr_o == WR_SRST);
        if (wr_stb)      step = !wr_hold;
        else if (rd_stb) step = (ptr_o != LAST);
        else             step = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_o <= '0;
        else if (ld)    ptr_o <= ld_val;
        else if (step)  ptr_o <= ptr_o + 1'b1;
    end

    AST_PTR_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !wr_stb && !ld && ptr_o != LAST |=> ptr_o == $past(ptr_o) + 1'b1); // R3
    AST_PTR_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !wr_stb && !ld && ptr_o == LAST |=> ptr_o == LAST); // R3
    AST_PTR_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && !ld && (ptr_o == WR_TRIG || ptr_o == WR_ACK || ptr_o == WR_CTL2 || ptr_o == WR_SRST)
        |=> $stable(ptr_o)); // R4
    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr_o == $past(ld_val)); // R5
endmodule

// File: rtl/cdc_rd_hist.sv
module cdc_rd_hist #(
    parameter int          NREG = 16,
    parameter logic [15:0] MASK = 16'h73F2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    rd_en,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic                    full
);
    logic [NREG-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) seen <= '0;
        else if (rd_en)    seen <= seen | (NREG'(1) << rd_idx);
    end

    assign full = ((seen & NREG'(MASK)) == NREG'(MASK));

    AST_HIST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !full); // R11
endmodule

// File: rtl/cdc_xfer_fsm.sv
module cdc_xfer_fsm
    import cdc_reg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic active,
    output logic trig
);
    xf_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            XF_IDLE: if (start) state_nx = XF_BUSY;
            XF_BUSY: if (!start && stop) state_nx = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= XF_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trig <= 1'b0;
        else        trig <= start;
    end

    assign active = (state == XF_BUSY);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active); // R7
    AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> active); // R7
endmodule

// File: rtl/cdc_regfile.sv
module cdc_regfile
    import cdc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_ld,
    input  logic [PTR_W-1:0]  ptr_ld_val,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr_q,
    input  logic [BYTE_W-1:0] cmd_in,
    input  logic              hdr_upd,
    input  logic [BYTE_W-1:0] msf_min,
    input  logic [BYTE_W-1:0] msf_sec,
    input  logic [BYTE_W-1:0] msf_frm,
    input  logic              dec_evt,
    input  logic              xfer_done,
    output logic              xfer_active,
    output logic              xfer_trig,
    output logic              xfer_ack,
    output logic              soft_rst,
    output logic [CNT_W-1:0]  bcnt_q,
    output logic [CNT_W-1:0]  daddr_q,
    output logic [3*BYTE_W-1:0] ctl_q,
    output logic [BYTE_W-1:0] subout_q,
    output logic [BYTE_W-1:0] hcfg_q
);
    regs_t r;
    logic  rd_only;
    logic  hist_full;
    logic  do_srst;
    logic  do_start;
    logic  do_stop;

    assign rd_only  = rd_stb && !wr_stb;
    assign do_srst  = wr_stb && (ptr_q == WR_SRST);
    assign do_start = wr_stb && (ptr_q == WR_TRIG) && r.hcfg[HCFG_XFER_EN];
    assign do_stop  = do_srst || xfer_done ||
                      (wr_stb && (ptr_q == WR_HCFG) && !wdata[HCFG_XFER_EN]);

    cdc_ptr_seq u_ptr (
        .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .ld_val(ptr_ld_val),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .ptr_o(ptr_q)
    );

    cdc_rd_hist #(.NREG(16), .MASK(16'h73F2)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(do_srst), .rd_en(rd_only),
        .rd_idx(ptr_q), .full(hist_full)
    );

    cdc_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(do_start), .stop(do_stop),
        .active(xfer_active), .trig(xfer_trig)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r        <= REG_RST;
            xfer_ack <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            xfer_ack <= 1'b0;
            soft_rst <= 1'b0;
            if (hdr_upd) begin
                if (r.dctl[1][DCTL1_ZHDR]) r.hdr <= '0;
                else r.hdr <= {8'h01, msf_frm, msf_sec, msf_min};
            end
            if (dec_evt) r.hsts[HSTS_DEC_N] <= 1'b0;
            if (xfer_done) begin
                r.hsts[HSTS_IDLE] <= 1'b1;
                if (r.hcfg[HCFG_DTE_IE]) r.hsts[HSTS_DTE_N] <= 1'b0;
            end
            if (wr_stb) begin
                unique case (ptr_q)
                    4'd0:  r.subout <= wdata;
                    4'd1: begin
                        r.hcfg <= wdata;
                        if (!wdata[HCFG_XFER_EN]) begin
                            r.bcnt <= '0;
                            r.hsts[HSTS_IDLE] <= 1'b1;
                        end
                    end
                    4'd2:  r.bcnt[7:0]   <= wdata;
                    4'd3:  r.bcnt[15:8]  <= wdata;
                    4'd4:  r.daddr[7:0]  <= wdata;
                    4'd5:  r.daddr[15:8] <= wdata;
                    4'd6:  if (r.hcfg[HCFG_XFER_EN]) r.hsts[HSTS_IDLE] <= 1'b0;
                    4'd7: begin
                        r.hsts[HSTS_DTE_N] <= 1'b1;
                        xfer_ack <= 1'b1;
                    end
                    4'd8:  r.waddr[7:0]  <= wdata;
                    4'd9:  r.waddr[15:8] <= wdata;
                    4'd10: r.dctl[0]     <= wdata;
                    4'd11: r.dctl[1]     <= wdata;
                    4'd12: r.bptr[7:0]   <= wdata;
                    4'd13: r.bptr[15:8]  <= wdata;
                    4'd14: r.dctl[2]     <= wdata;
                    4'd15: begin
                        r        <= REG_RST;
                        soft_rst <= 1'b1;
                    end
                endcase
            end else if (rd_stb && ptr_q == RD_DSTS3) begin
                r.hsts[HSTS_DEC_N] <= 1'b1;
                if (r.dctl[0][DCTL0_ARM] && r.hcfg[HCFG_DEC_IE] && hist_full)
                    r.dsts[3] <= 8'h80;
            end
        end
    end

    always_comb begin
        unique case (ptr_q)
            4'd0:  rdata = cmd_in;
            4'd1:  rdata = r.hsts;
            4'd2:  rdata = r.bcnt[7:0];
            4'd3:  rdata = r.bcnt[15:8];
            4'd4:  rdata = r.hdr[0];
            4'd5:  rdata = r.hdr[1];
            4'd6:  rdata = r.hdr[2];
            4'd7:  rdata = r.hdr[3];
            4'd8:  rdata = r.bptr[7:0];
            4'd9:  rdata = r.bptr[15:8];
            4'd10: rdata = r.waddr[7:0];
            4'd11: rdata = r.waddr[15:8];
            4'd12: rdata = r.dsts[0];
            4'd13: rdata = r.dsts[1];
            4'd14: rdata = r.dsts[2];
            4'd15: rdata = r.dsts[3];
        endcase
    end

    assign bcnt_q   = r.bcnt;
    assign daddr_q  = r.daddr;
    assign ctl_q    = r.dctl;
    assign subout_q = r.subout;
    assign hcfg_q   = r.hcfg;

    AST_HCFG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && ptr_q == WR_HCFG && !wdata[HCFG_XFER_EN]
        |=> bcnt_q == '0 && r.hsts[HSTS_IDLE] && !xfer_active); // R6
    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && ptr_q == WR_TRIG && !hcfg_q[HCFG_XFER_EN] |=> !xfer_trig); // R7
    AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb && ptr_q == WR_ACK |=> r.hsts[HSTS_DTE_N] && xfer_ack); // R8
    AST_DSTS3_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_only && ptr_q == RD_DSTS3 |=> r.hsts[HSTS_DEC_N]); // R9
    AST_SRST_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        do_srst |=> r.hsts == 8'hFF && soft_rst && !xfer_active && $stable(ptr_q)); // R11
    AST_DEC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dec_evt && !wr_stb && !rd_stb |=> !r.hsts[HSTS_DEC_N]); // R13
endmodule

// File: tb/cdc_regfile_tb_top.sv
`timescale 1ns/1ps
module cdc_regfile_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ptr_ld = 0, rd_stb = 0, wr_stb = 0, hdr_upd = 0, dec_evt = 0, xfer_done = 0;
    logic [3:0] ptr_ld_val = '0;
    logic [7:0] wdata = '0, cmd_in = 8'hC3, msf_min = '0, msf_sec = '0, msf_frm = '0;
    logic [7:0] rdata, subout_q, hcfg_q;
    logic [3:0] ptr_q;
    logic xfer_active, xfer_trig, xfer_ack, soft_rst;
    logic [15:0] bcnt_q, daddr_q;
    logic [23:0] ctl_q;

    always #2 clk = ~clk;

    cdc_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .ptr_q(ptr_q),
        .cmd_in(cmd_in), .hdr_upd(hdr_upd), .msf_min(msf_min), .msf_sec(msf_sec),
        .msf_frm(msf_frm), .dec_evt(dec_evt), .xfer_done(xfer_done),
        .xfer_active(xfer_active), .xfer_trig(xfer_trig), .xfer_ack(xfer_ack),
        .soft_rst(soft_rst), .bcnt_q(bcnt_q), .daddr_q(daddr_q), .ctl_q(ctl_q),
        .subout_q(subout_q), .hcfg_q(hcfg_q)
    );

    int checks = 0, errors = 0;
    string tg = "R1";

    // behavioural reference state
    int m_ptr, m_sub, m_hcfg, m_hsts, m_bcnt, m_daddr, m_wa, m_bp, m_hist;
    int m_hdr[4], m_st[4], m_ctl[3];
    bit m_act, m_trig, m_ack, m_srst;

    task automatic m_defaults();
        m_sub = 0; m_hcfg = 0; m_hsts = 'hFF; m_bcnt = 0; m_daddr = 0;
        m_wa = 4704; m_bp = 0; m_hist = 0; m_act = 0;
        m_hdr = '{0, 0, 0, 1};
        m_st  = '{'h80, 0, 0, 0};
        m_ctl = '{0, 0, 0};
    endtask

    function automatic int m_read(int p);
        case (p)
            0: return cmd_in;
            1: return m_hsts;
            2: return m_bcnt & 'hFF;
            3: return (m_bcnt >> 8) & 'hFF;
            4, 5, 6, 7: return m_hdr[p-4];
            8: return m_bp & 'hFF;
            9: return (m_bp >> 8) & 'hFF;
            10: return m_wa & 'hFF;
            11: return (m_wa >> 8) & 'hFF;
            default: return m_st[p-12];
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(tg, "rdata", int'(rdata), m_read(m_ptr));
        check(tg, "ptr", int'(ptr_q), m_ptr);
        check(tg, "active", int'(xfer_active), int'(m_act));
        check(tg, "trig", int'(xfer_trig), int'(m_trig));
        check(tg, "ack", int'(xfer_ack), int'(m_ack));
        check(tg, "srst", int'(soft_rst), int'(m_srst));
        check(tg, "bcnt", int'(bcnt_q), m_bcnt);
        check(tg, "daddr", int'(daddr_q), m_daddr);
        check(tg, "ctl", int'(ctl_q), (m_ctl[2] << 16) | (m_ctl[1] << 8) | m_ctl[0]);
        check(tg, "subout", int'(subout_q), m_sub);
        check(tg, "hcfg", int'(hcfg_q), m_hcfg);
    endtask

    task automatic m_edge(bit rd, bit wr, bit ld, int ldv, int wd, bit hu, bit dv, bit dn);
        int p = m_ptr;
        m_trig = 0; m_ack = 0; m_srst = 0;
        if (hu) begin
            if (m_ctl[1] & 1) m_hdr = '{0, 0, 0, 0};
            else m_hdr = '{int'(msf_min), int'(msf_sec), int'(msf_frm), 1};
        end
        if (dv) m_hsts &= ~'h20;
        if (dn) begin
            m_hsts |= 'h08;
            if (m_hcfg & 'h40) m_hsts &= ~'h40;
            m_act = 0;
        end
        if (wr) begin
            case (p)
                0: m_sub = wd;
                1: begin
                    m_hcfg = wd;
                    if (!(wd & 2)) begin m_bcnt = 0; m_hsts |= 8; m_act = 0; end
                end
                2: m_bcnt = (m_bcnt & 'hFF00) | wd;
                3: m_bcnt = (m_bcnt & 'hFF) | (wd << 8);
                4: m_daddr = (m_daddr & 'hFF00) | wd;
                5: m_daddr = (m_daddr & 'hFF) | (wd << 8);
                6: if (m_hcfg & 2) begin m_hsts &= ~8; m_act = 1; m_trig = 1; end
                7: begin m_hsts |= 'h40; m_ack = 1; end
                8: m_wa = (m_wa & 'hFF00) | wd;
                9: m_wa = (m_wa & 'hFF) | (wd << 8);
                10: m_ctl[0] = wd;
                11: m_ctl[1] = wd;
                12: m_bp = (m_bp & 'hFF00) | wd;
                13: m_bp = (m_bp & 'hFF) | (wd << 8);
                14: m_ctl[2] = wd;
                default: begin m_defaults(); m_srst = 1; end
            endcase
        end else if (rd) begin
            if (p == 15) begin
                m_hsts |= 'h20;
                if ((m_ctl[0] & 'h80) && (m_hcfg & 'h20) && ((m_hist & 'h73F2) == 'h73F2))
                    m_st[3] = 'h80;
            end
            m_hist |= (1 << p);
        end
        if (ld) m_ptr = ldv;
        else if (wr) begin
            if (!(p == 6 || p == 7 || p == 14 || p == 15)) m_ptr = p + 1;
        end else if (rd) begin
            if (p != 15) m_ptr = p + 1;
        end
    endtask

    task automatic step(bit rd, bit wr, bit ld, int ldv, int wd, bit hu, bit dv, bit dn);
        compare_all();
        rd_stb = rd; wr_stb = wr; ptr_ld = ld; ptr_ld_val = 4'(ldv);
        wdata = 8'(wd); hdr_upd = hu; dec_evt = dv; xfer_done = dn;
        m_edge(rd, wr, ld, ldv, wd, hu, dv, dn);
        @(posedge clk);
        @(negedge clk);
        rd_stb = 0; wr_stb = 0; ptr_ld = 0; hdr_upd = 0; dec_evt = 0; xfer_done = 0;
    endtask

    task automatic ld_ptr(int v);  step(0, 0, 1, v, 0, 0, 0, 0); endtask
    task automatic rd1();          step(1, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr1(int d);     step(0, 1, 0, 0, d, 0, 0, 0); endtask
    task automatic idle();         step(0, 0, 0, 0, 0, 0, 0, 0); endtask

    bit finished = 0;
    initial begin
        #800000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        m_ptr = 0; m_trig = 0; m_ack = 0; m_srst = 0;
        m_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values read through the map (R2)
        tg = "R1"; idle();
        tg = "R2"; for (int i = 0; i < 15; i++) rd1();
        tg = "R3"; rd1(); rd1();
        // R4 write sweep 0..5, then hold at trigger
        tg = "R5"; ld_ptr(0);
        tg = "R4";
        wr1('h5A); wr1('h62); wr1('h34); wr1('h12); wr1('hCD); wr1('hAB);
        tg = "R7"; wr1(0); wr1(0); idle();
        tg = "R8"; ld_ptr(7); wr1(0); wr1(0); idle();
        tg = "R13";
        step(0, 0, 0, 0, 0, 0, 1, 0);
        ld_ptr(1); idle();
        step(0, 0, 0, 0, 0, 0, 0, 1); idle();
        step(0, 1, 0, 0, 'h62, 0, 1, 1);          // write wins over events on same cycle
        tg = "R4"; ld_ptr(8);
        wr1('h34); wr1('h12); wr1('h80); wr1('h00); wr1('h78); wr1('h56); wr1('h9E); wr1('h9F);
        tg = "R10";
        msf_min = 8'h12; msf_sec = 8'h34; msf_frm = 8'h56;
        step(0, 0, 0, 0, 0, 1, 0, 0);
        ld_ptr(4); rd1(); rd1(); rd1(); rd1();
        ld_ptr(11); wr1('h01);
        step(0, 0, 0, 0, 0, 1, 0, 0);
        ld_ptr(4); rd1(); rd1(); rd1(); rd1();
        ld_ptr(11); wr1('h00);
        tg = "R6"; ld_ptr(6); wr1(0); ld_ptr(1); wr1('h60); idle();
        ld_ptr(1); rd1();
        tg = "R7"; ld_ptr(6); wr1(0); idle();
        tg = "R11"; ld_ptr(1); wr1('h22); ld_ptr(6); wr1(0);
        ld_ptr(15); wr1(0); idle();
        ld_ptr(0); for (int i = 0; i < 16; i++) rd1();
        tg = "R9"; ld_ptr(15); wr1(0);
        ld_ptr(1); wr1('h20); ld_ptr(10); wr1('h80);
        step(0, 0, 0, 0, 0, 0, 1, 0);
        ld_ptr(15); rd1(); ld_ptr(1); rd1(); idle();
        ld_ptr(4); for (int i = 0; i < 6; i++) rd1();
        ld_ptr(12); rd1(); rd1();
        ld_ptr(15); rd1(); rd1();                 // index 14 still missing: no load
        ld_ptr(14); rd1(); rd1(); rd1(); idle();
        tg = "R12"; ld_ptr(12); step(1, 1, 0, 0, 'hA5, 0, 0, 0); idle();
        ld_ptr(8); rd1();
        tg = "R5"; ld_ptr(2); step(1, 0, 1, 9, 0, 0, 0, 0); idle();
        step(0, 1, 1, 3, 'h77, 0, 0, 0); idle();
        compare_all();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule